// File: doc/BRIEF.md
# Byte-Laned Asynchronous SRAM Model

This block is a synthesizable behavioural model of a 16-bit-wide static RAM with a 17-bit word address. It is meant to stand in for an external asynchronous memory inside a simulation or an emulation fabric. The control pins are all active low: a chip select, a write enable, an output enable and two byte selects. The pins are decoded every cycle into one of four modes: deselected, outputs quiet, read and write. Each of the two 8-bit lanes then acts on its own select.

There are no bidirectional pins. Each lane has an 8-bit value output and a drive flag, so a lane that floats can be observed directly. Writes are sampled by the system clock. A write lands when the gated strobe of a lane ends, which is the first clock that sees it inactive. The address and data are the ones sampled on the last clock the strobe was active. Reads follow the address combinationally. A read in the cycle right after a strobe ends already returns the new byte. The array depth is a parameter, so simulations can use a small array. The address port keeps its full 17 bits and the stored word is picked by the low address bits.

Top module: `byte_lane_sram`

## Requirements
- R1: While `cs_n` is 1, both `lo_drive` and `hi_drive` are 0 and no stored byte changes, whatever `we_n`, `oe_n`, the selects, the address or the data are doing.
- R2: With `cs_n`=0, `we_n`=1 and `oe_n`=1, both lanes float and nothing is written.
- R3: With `cs_n`=0, `we_n`=1 and `oe_n`=0, a lane whose select is 0 raises its drive flag and presents the stored byte at the current address. A lane whose select is 1 floats. While the address is held and the lane keeps driving, its value does not change.
- R4: With `cs_n`=0 and `we_n`=0, `oe_n` has no effect: both lanes float, and every lane whose select is 0 stores its byte of `wdata`.
- R5: During a write, a lane whose select is 1 keeps its stored byte.
- R6: With `cs_n`=0 and both selects at 1, both lanes float and no write takes place.
- R7: `lo_sel_n` governs `wdata[7:0]` and `lo_q`. `hi_sel_n` governs `wdata[15:8]` and `hi_q`.
- R8: A lane's write strobe (`cs_n`=0, `we_n`=0 and its select at 0, sampled at a rising clock edge) commits at the first edge that samples it inactive. The commit uses the address and data sampled at the last active edge. A read in the cycle between strobe release and the commit already returns the new byte.
- R9: A lane whose drive flag is 0 shows 0 on its value output.
- R10: The word index is `addr` modulo `DEPTH`, where `DEPTH` is a power of two. Addresses that differ only above the index bits reach the same word.
- R11: While `rst_n` is 0 at a clock edge, any pending strobe is cleared. A strobe seen only during reset commits nothing. Stored contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write strobes |
| rst_n | input | 1 | Synchronous active-low reset of the pending-strobe state |
| addr | input | ADDR_W (17) | Word address |
| wdata | input | 2*LANE_W (16) | Write data; bits 7:0 lower lane, 15:8 upper lane |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lo_sel_n | input | 1 | Lower lane select, active low |
| hi_sel_n | input | 1 | Upper lane select, active low |
| lo_q | output | LANE_W (8) | Lower lane read value, 0 when floating |
| lo_drive | output | 1 | Lower lane drives the bus |
| hi_q | output | LANE_W (8) | Upper lane read value, 0 when floating |
| hi_drive | output | 1 | Upper lane drives the bus |

## Verification
The hardest case to reach from the ports is the cycle in which a write strobe has just ended but has not yet been committed to the array. Only the forwarding path can give the right answer there. The stimulus reaches it by following a write cycle at once with a read of the same address, with no idle cycle between them. A second sequence holds the strobe low over two edges while the data changes, to show that the last sample wins. A third sequence asserts reset while a strobe is active, to show that nothing commits.

// File: rtl/sram_bl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the decoded operating mode of the byte-laned SRAM.
package sram_bl_pkg;
    // Two byte lanes: index 0 is the lower byte, index 1 the upper byte.
    localparam int unsigned LANES = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,   // chip deselected
        OP_QUIET = 2'd1,   // selected, outputs disabled, no write
        OP_READ  = 2'd2,   // selected lanes drive stored data
        OP_WRITE = 2'd3    // selected lanes capture input data
    } sram_op_e;
endpackage

// File: rtl/sram_bl_decode.sv
`timescale 1ns/1ps
// Module: sram_bl_decode
// Decodes the active-low control pins into one mode and then into a
// drive request and a write request for each lane.
// Assumes: purely combinational; write enable takes priority over output enable.
module sram_bl_decode
    import sram_bl_pkg::*;
#(
    parameter int unsigned NLANE = LANES
) (
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [NLANE-1:0] sel_n,
    output logic [NLANE-1:0] drv,
    output logic [NLANE-1:0] wact
);

    sram_op_e op;

    // Mode selection by truth-table priority: chip select, then write, then output enable.
    always_comb begin
        if (cs_n)       op = OP_IDLE;
        else if (!we_n) op = OP_WRITE;
        else if (!oe_n) op = OP_READ;
        else            op = OP_QUIET;
    end

    // Per-lane qualification of the mode by the lane's own select.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_comb begin
            drv[g]  = (op == OP_READ)  && !sel_n[g];
            wact[g] = (op == OP_WRITE) && !sel_n[g];
        end
    end

endmodule

// File: rtl/sram_bl_lane.sv
`timescale 1ns/1ps
// Module: sram_bl_lane
// One byte lane: its storage column, the pending-write register that commits
// when the lane's strobe ends, and the read path with forwarding of that
// pending write.
// Assumes: DEPTH is a power of two; storage has no reset.
module sram_bl_lane #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wact,
    input  logic              drv,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] q,
    output logic              drive
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic              act_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LANE_W-1:0] din_q;
    logic              commit;
    logic [LANE_W-1:0] rd_val;

    // Strobe history: remembers whether the strobe was active at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= wact;
    end

    // Capture address and data on each edge the strobe is active; the last one wins.
    always_ff @(posedge clk) begin
        if (wact) begin
            idx_q <= idx;
            din_q <= din;
        end
    end

    // The strobe has just ended: the captured byte is due for the array.
    always_comb commit = act_q && !wact;

    // Array update at the end of the strobe.
    always_ff @(posedge clk) begin
        if (commit) mem[idx_q] <= din_q;
    end

    // Read path, forwarding a commit that is still pending to the same index.
    always_comb begin
        if (commit && (idx_q == idx)) rd_val = din_q;
        else                          rd_val = mem[idx];
    end

    // Output stage: the value is forced to zero while the lane floats.
    always_comb begin
        drive = drv;
        q     = drv ? rd_val : '0;
    end

endmodule

// File: rtl/byte_lane_sram.sv
`timescale 1ns/1ps
// Module: byte_lane_sram
// Two-lane asynchronous SRAM model with a 17-bit word address. It decodes
// the control pins once and gives each lane its own drive and write request.
// Each lane shows a value and a drive flag instead of a tri-state pin.
// Assumes: DEPTH is a power of two no larger than 2**ADDR_W; the low address
// bits select the word.
module byte_lane_sram
    import sram_bl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lo_sel_n,
    input  logic              hi_sel_n,
    output logic [LANE_W-1:0] lo_q,
    output logic              lo_drive,
    output logic [LANE_W-1:0] hi_q,
    output logic              hi_drive
);

    logic [LANES-1:0]  sel_n;
    logic [LANES-1:0]  drv;
    logic [LANES-1:0]  wact;
    logic [LANES-1:0]  lane_drive;
    logic [LANE_W-1:0] lane_q [LANES];
    logic [IDX_W-1:0]  idx;

    // Gather the lane selects and fold the address onto the array depth.
    always_comb begin
        sel_n = {hi_sel_n, lo_sel_n};
        idx   = addr[IDX_W-1:0];
    end

    sram_bl_decode #(.NLANE(LANES)) u_dec (
        .cs_n  (cs_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .sel_n (sel_n),
        .drv   (drv),
        .wact  (wact)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_bl_lane #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wact  (wact[g]),
            .drv   (drv[g]),
            .idx   (idx),
            .din   (wdata[g*LANE_W +: LANE_W]),
            .q     (lane_q[g]),
            .drive (lane_drive[g])
        );
    end

    // Map the lanes onto the named outputs: lane 0 is the lower byte.
    always_comb begin
        lo_q     = lane_q[0];
        lo_drive = lane_drive[0];
        hi_q     = lane_q[1];
        hi_drive = lane_drive[1];
    end

endmodule

// File: rtl/byte_lane_sram_chk.sv
`timescale 1ns/1ps
// Module: byte_lane_sram_chk
// Port-level protocol checks for byte_lane_sram, attached with bind.
// Assumes: signals are sampled at the rising clock edge; checks pause during reset.
module byte_lane_sram_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              lo_sel_n,
    input logic              hi_sel_n,
    input logic [LANE_W-1:0] lo_q,
    input logic              lo_drive,
    input logic [LANE_W-1:0] hi_q,
    input logic              hi_drive
);

    // R1
    idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!lo_drive && !hi_drive));

    // R2
    quiet_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |-> (!lo_drive && !hi_drive));

    // R4
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |-> (!lo_drive && !hi_drive));

    // R6
    nosel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_sel_n && hi_sel_n) |-> (!lo_drive && !hi_drive));

    // R3
    lo_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |-> (lo_drive == !lo_sel_n));

    // R3
    hi_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |-> (hi_drive == !hi_sel_n));

    // R3
    lo_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_drive && $past(lo_drive) && $stable(addr)) |-> $stable(lo_q));

    // R3
    hi_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_drive && $past(hi_drive) && $stable(addr)) |-> $stable(hi_q));

    // R9
    float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!lo_drive -> (lo_q == '0)) && (!hi_drive -> (hi_q == '0))));

endmodule

bind byte_lane_sram byte_lane_sram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/byte_lane_sram_test.sv
`timescale 1ns/1ps
// Scoreboard bench for byte_lane_sram: driver tasks apply pin states and push
// expected lane results; a monitor pops and compares them.
module byte_lane_sram_test;
    localparam int unsigned DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1;
    logic [7:0]  lo_q, hi_q;
    logic        lo_drive, hi_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       tag_q[$];
    logic [17:0] exp_q[$];
    event        chk_ev;

    byte_lane_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n),
        .lo_q(lo_q), .lo_drive(lo_drive), .hi_q(hi_q), .hi_drive(hi_drive)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Apply one cycle of pin values at the falling edge.
    task automatic put(input logic c, input logic w, input logic o,
                       input logic l, input logic h,
                       input logic [16:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = c; we_n = w; oe_n = o; lo_sel_n = l; hi_sel_n = h;
        addr = a; wdata = d;
    endtask

    // Push the expected lane result for the current cycle, mid-way to the next edge.
    task automatic expect_out(input string tag, input logic ld, input logic [7:0] lq,
                              input logic hd, input logic [7:0] hq);
        #5;
        tag_q.push_back(tag);
        exp_q.push_back({ld, lq, hd, hq});
        -> chk_ev;
    endtask

    task automatic idle();
        put(1, 1, 1, 1, 1, '0, '0);
    endtask

    // Write cycle with output enable low (ignored), then one idle cycle for the commit.
    task automatic wr(input logic [16:0] a, input logic [15:0] d,
                      input logic l, input logic h);
        put(0, 0, 0, l, h, a, d);
        expect_out("R4 write floats both lanes", 0, 8'h00, 0, 8'h00);
        idle();
    endtask

    task automatic rd(input string tag, input logic [16:0] a, input logic l, input logic h,
                      input logic ld, input logic [7:0] lq, input logic hd, input logic [7:0] hq);
        put(0, 1, 0, l, h, a, '0);
        expect_out(tag, ld, lq, hd, hq);
    endtask

    // Monitor: compare the design's lanes against each queued expectation.
    initial begin
        forever begin
            @(chk_ev);
            while (tag_q.size() > 0) begin
                string       t;
                logic [17:0] e, act;
                t   = tag_q.pop_front();
                e   = exp_q.pop_front();
                act = {lo_drive, lo_q, hi_drive, hi_q};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: got drv_lo=%b lo=%h drv_hi=%b hi=%h, expected drv_lo=%b lo=%h drv_hi=%b hi=%h",
                             t, act[17], act[16:9], act[8], act[7:0], e[17], e[16:9], e[8], e[7:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11 / R1: reset state floats.
        idle(); idle();
        expect_out("R1 R11 reset floats", 0, 8'h00, 0, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        wr(17'd5, 16'h1234, 0, 0);
        rd("R3 R7 word read", 17'd5, 0, 0, 1, 8'h34, 1, 8'h12);
        rd("R3 R9 lower only", 17'd5, 0, 1, 1, 8'h34, 0, 8'h00);
        rd("R3 R7 upper only", 17'd5, 1, 0, 0, 8'h00, 1, 8'h12);

        wr(17'd5, 16'hBEAA, 0, 1);
        rd("R5 lower write keeps upper", 17'd5, 0, 0, 1, 8'hAA, 1, 8'h12);
        wr(17'd5, 16'h77CC, 1, 0);
        rd("R5 upper write keeps lower", 17'd5, 0, 0, 1, 8'hAA, 1, 8'h77);

        put(0, 0, 0, 1, 1, 17'd5, 16'h0000);
        expect_out("R6 no select floats", 0, 8'h00, 0, 8'h00);
        idle();
        rd("R6 no select writes nothing", 17'd5, 0, 0, 1, 8'hAA, 1, 8'h77);

        put(0, 1, 1, 0, 0, 17'd5, 16'h5A5A);
        expect_out("R2 outputs disabled float", 0, 8'h00, 0, 8'h00);
        rd("R2 nothing written", 17'd5, 0, 0, 1, 8'hAA, 1, 8'h77);

        put(1, 0, 0, 0, 0, 17'd5, 16'h5555);
        expect_out("R1 deselect floats under write pins", 0, 8'h00, 0, 8'h00);
        idle();
        rd("R1 deselect writes nothing", 17'd5, 0, 0, 1, 8'hAA, 1, 8'h77);

        // R8: read in the cycle right after the strobe ends sees the new word.
        put(0, 0, 1, 0, 0, 17'd7, 16'hC3A5);
        rd("R8 forwarded read", 17'd7, 0, 0, 1, 8'hA5, 1, 8'hC3);
        rd("R8 committed read", 17'd7, 0, 0, 1, 8'hA5, 1, 8'hC3);

        // R8: strobe held over two edges; the last sampled data wins.
        put(0, 0, 1, 0, 0, 17'd9, 16'h1111);
        put(0, 0, 1, 0, 0, 17'd9, 16'h2222);
        idle();
        rd("R8 last sample wins", 17'd9, 0, 0, 1, 8'h22, 1, 8'h22);

        // R10: the index wraps modulo DEPTH.
        rd("R10 alias read", 17'd5 + 17'(DEPTH), 0, 0, 1, 8'hAA, 1, 8'h77);
        wr(17'd7 + 17'(2 * DEPTH), 16'h0F0E, 0, 0);
        rd("R10 alias write", 17'd7, 0, 0, 1, 8'h0E, 1, 8'h0F);

        // R11: a strobe seen only during reset commits nothing.
        @(negedge clk); rst_n = 1'b0;
        cs_n = 0; we_n = 0; oe_n = 1; lo_sel_n = 0; hi_sel_n = 0;
        addr = 17'd9; wdata = 16'h9999;
        put(0, 0, 1, 0, 0, 17'd9, 16'h9999);
        idle();
        @(negedge clk); rst_n = 1'b1;
        idle();
        rd("R11 reset blocks commit", 17'd9, 0, 0, 1, 8'h22, 1, 8'h22);

        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule